// File: doc/BRIEF.md
# Dual-Channel Serial Sample Input Register with Segment Encoder

This block sits in front of a pair of audio converter cores. A single bit clock serves two serial sample streams, one for the left channel and one for the right. Each stream fills its own 18-bit shift register, most significant bit first. Each channel has its own strobe, and a high-to-low transition on that strobe copies the channel's shift register into a holding register. The two channels can be updated independently. The block still works when the two strobes come from one common wire, or when both channels are fed from one data wire.

Samples arrive in two's-complement form. For each held sample, the block inverts the sign bit to give offset-binary code. The top four offset-binary bits become a 15-element thermometer vector that drives equally weighted segment elements. The lower 14 bits pass through unchanged as the binary-weighted field. The strobes are sampled in the bit-clock domain, so every output update happens on a clock edge.

Top module: `dual_dac_input`

## Requirements
- R1: A synchronous active-high reset clears both shift registers. It sets both held words to 0 (the two's-complement zero code), both thermometer vectors to 15'h00FF and both binary fields to 0.
- R2: Each rising clock edge shifts one bit into each channel's register, most significant bit first. A load captures the 18 most recent bits, up to and including the bit taken on the edge where the strobe is first sampled low. Bits sent earlier than that are pushed out.
- R3: The held word, thermometer vector and binary field change on the first rising edge after the edge that samples the strobe low. At the edge that samples the strobe low, the old values remain.
- R4: A strobe that stays low, or stays high, causes no further load. The outputs keep their values while data keeps shifting.
- R5: A falling edge on one channel's strobe leaves the other channel's outputs unchanged.
- R6: If both strobes fall on the same clock, both channels load on the same clock.
- R7: If both data inputs carry the same stream, both channels hold the same word.
- R8: Let N be the 4-bit number formed by the inverted bit 17 followed by bits 16..14 of the held word. The thermometer vector then has exactly N ones, in bits 0 to N-1. The code 18'h20000 gives all zeros and 18'h1FFFF gives all ones.
- R9: The binary field equals bits 13..0 of the held word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; data is shifted on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dataL | input | 1 | Left serial data |
| dataR | input | 1 | Right serial data |
| latL | input | 1 | Left load strobe; a falling edge loads |
| latR | input | 1 | Right load strobe; a falling edge loads |
| holdL | output | 18 | Left held two's-complement word |
| thermoL | output | 15 | Left segment thermometer vector |
| binL | output | 14 | Left binary-weighted field |
| holdR | output | 18 | Right held word |
| thermoR | output | 15 | Right segment thermometer vector |
| binR | output | 14 | Right binary-weighted field |

## Verification
The hardest case to produce is a strobe that stays low for many clocks while data keeps moving. A design that loads on level rather than on edge would keep overwriting the held word, and from the ports that case looks just like a second frame. The bench therefore holds a strobe low across a full new frame of different data and checks that nothing moved. It also sends frames longer than 18 bits, so that any leftover bits become visible. A separate directed step checks the one-cycle delay, sampling the outputs both between the two edges and after them.

// File: rtl/dac_in_pkg.sv
package dac_in_pkg;
  localparam int DefDataW   = 18;
  localparam int DefSegBits = 4;

  // load requests from the strobe sampler to the datapath
  typedef struct packed {
    logic loadL;
    logic loadR;
  } strobes_t;
endpackage

// File: rtl/dac_in_ctrl.sv
module dac_in_ctrl
  import dac_in_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     latL,
  input  logic     latR,
  output strobes_t strb
);
  // two-stage history of each strobe, sampled on the bit clock
  logic [1:0] latNow;
  logic [1:0] latOld;

  always_ff @(posedge clk) begin
    if (rst) begin
      latNow <= 2'b00;
      latOld <= 2'b00;
    end else begin
      latNow <= {latR, latL};
      latOld <= latNow;
    end
  end

  // high in the previous sample, low in the newest one
  always_comb begin
    strb.loadL = latOld[0] & ~latNow[0];
    strb.loadR = latOld[1] & ~latNow[1];
  end
endmodule

// File: rtl/dac_in_chan.sv
module dac_in_chan #(
  parameter  int DataW   = 18,
  parameter  int SegBits = 4,
  localparam int SegN    = (1 << SegBits) - 1,
  localparam int LsbW    = DataW - SegBits
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             serIn,
  input  logic             load,
  output logic [DataW-1:0] holdWord,
  output logic [SegN-1:0]  thermo,
  output logic [LsbW-1:0]  binField
);
  localparam int MidN = 1 << (SegBits - 1);
  localparam logic [SegN:0] ZeroFull = (SegN+1)'((1 << MidN) - 1);
  localparam logic [SegN-1:0] ZeroTherm = ZeroFull[SegN-1:0];

  logic [DataW-1:0]   shiftReg;
  logic [SegBits-1:0] offTop;
  logic [SegN-1:0]    thermNext;

  always_ff @(posedge clk) begin
    if (rst) shiftReg <= '0;
    else     shiftReg <= {shiftReg[DataW-2:0], serIn};
  end

  // sign inversion turns two's complement into offset binary
  assign offTop = {~shiftReg[DataW-1], shiftReg[DataW-2:LsbW]};

  for (genvar i = 0; i < SegN; i++) begin : g_seg
    assign thermNext[i] = (offTop > SegBits'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdWord <= '0;
      thermo   <= ZeroTherm;
      binField <= '0;
    end else if (load) begin
      holdWord <= shiftReg;
      thermo   <= thermNext;
      binField <= shiftReg[LsbW-1:0];
    end
  end
endmodule

// File: rtl/dac_in_datapath.sv
module dac_in_datapath
  import dac_in_pkg::*;
#(
  parameter  int DataW   = 18,
  parameter  int SegBits = 4,
  localparam int SegN    = (1 << SegBits) - 1,
  localparam int LsbW    = DataW - SegBits
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            serIn,
  input  strobes_t              strb,
  output logic [1:0][DataW-1:0] holdArr,
  output logic [1:0][SegN-1:0]  thermArr,
  output logic [1:0][LsbW-1:0]  binArr
);
  logic [1:0] loadVec;
  assign loadVec = {strb.loadR, strb.loadL};

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    dac_in_chan #(.DataW(DataW), .SegBits(SegBits)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .serIn    (serIn[ch]),
      .load     (loadVec[ch]),
      .holdWord (holdArr[ch]),
      .thermo   (thermArr[ch]),
      .binField (binArr[ch])
    );
  end
endmodule

// File: rtl/dual_dac_input.sv
module dual_dac_input
  import dac_in_pkg::*;
#(
  parameter  int DataW   = DefDataW,
  parameter  int SegBits = DefSegBits,
  localparam int SegN    = (1 << SegBits) - 1,
  localparam int LsbW    = DataW - SegBits
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dataL,
  input  logic             dataR,
  input  logic             latL,
  input  logic             latR,
  output logic [DataW-1:0] holdL,
  output logic [SegN-1:0]  thermoL,
  output logic [LsbW-1:0]  binL,
  output logic [DataW-1:0] holdR,
  output logic [SegN-1:0]  thermoR,
  output logic [LsbW-1:0]  binR
);
  strobes_t              strb;
  logic [1:0][DataW-1:0] holdArr;
  logic [1:0][SegN-1:0]  thermArr;
  logic [1:0][LsbW-1:0]  binArr;

  dac_in_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .latL (latL),
    .latR (latR),
    .strb (strb)
  );

  dac_in_datapath #(.DataW(DataW), .SegBits(SegBits)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .serIn    ({dataR, dataL}),
    .strb     (strb),
    .holdArr  (holdArr),
    .thermArr (thermArr),
    .binArr   (binArr)
  );

  assign holdL   = holdArr[0];
  assign thermoL = thermArr[0];
  assign binL    = binArr[0];
  assign holdR   = holdArr[1];
  assign thermoR = thermArr[1];
  assign binR    = binArr[1];
endmodule

// File: rtl/dual_dac_input_chk.sv
module dual_dac_input_chk #(
  parameter  int DataW   = 18,
  parameter  int SegBits = 4,
  localparam int SegN    = (1 << SegBits) - 1,
  localparam int LsbW    = DataW - SegBits
) (
  input logic             clk,
  input logic             rst,
  input logic             latL,
  input logic             latR,
  input logic [DataW-1:0] holdL,
  input logic [SegN-1:0]  thermoL,
  input logic [LsbW-1:0]  binL,
  input logic [DataW-1:0] holdR,
  input logic [SegN-1:0]  thermoR,
  input logic [LsbW-1:0]  binR
);
  // independent view of the strobe edges, taken at the ports
  logic [1:0] seenA, seenB;
  always_ff @(posedge clk) begin
    if (rst) begin
      seenA <= 2'b00;
      seenB <= 2'b00;
    end else begin
      seenA <= {latR, latL};
      seenB <= seenA;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (holdL == '0 && holdR == '0 && binL == '0 && binR == '0 &&
             $countones(thermoL) == (1 << (SegBits-1)) && thermoL[0]));

  assert_hold_L_R4: assert property (@(posedge clk) disable iff (rst)
    !(seenB[0] && !seenA[0]) |=> $stable(holdL));

  assert_hold_R_R4: assert property (@(posedge clk) disable iff (rst)
    !(seenB[1] && !seenA[1]) |=> $stable(holdR));

  assert_count_L_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(thermoL) == int'({~holdL[DataW-1], holdL[DataW-2:LsbW]}));

  assert_count_R_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(thermoR) == int'({~holdR[DataW-1], holdR[DataW-2:LsbW]}));

  assert_shape_L_R8: assert property (@(posedge clk) disable iff (rst)
    ((thermoL + 1'b1) & thermoL) == '0);

  assert_shape_R_R8: assert property (@(posedge clk) disable iff (rst)
    ((thermoR + 1'b1) & thermoR) == '0);

  assert_bin_R9: assert property (@(posedge clk) disable iff (rst)
    binL == holdL[LsbW-1:0] && binR == holdR[LsbW-1:0]);
endmodule

bind dual_dac_input dual_dac_input_chk #(.DataW(DataW), .SegBits(SegBits)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .latL    (latL),
  .latR    (latR),
  .holdL   (holdL),
  .thermoL (thermoL),
  .binL    (binL),
  .holdR   (holdR),
  .thermoR (thermoR),
  .binR    (binR)
);

// File: tb/sim_dual_dac_input.sv
module sim_dual_dac_input;
  localparam int ClkPeriod = 10;
  localparam int NumVec    = 6;

  // {mask(R,L), left word, right word}
  localparam logic [37:0] VecTab [NumVec] = '{
    {2'b11, 18'h00000, 18'h00000},
    {2'b11, 18'h20000, 18'h1FFFF},
    {2'b01, 18'h12345, 18'h3ABCD},
    {2'b10, 18'h0F0F0, 18'h2C001},
    {2'b11, 18'h3FFFF, 18'h04000},
    {2'b11, 18'h1C000, 18'h24000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dataL = 1'b0, dataR = 1'b0, latL = 1'b1, latR = 1'b1;
  logic [17:0] holdL, holdR;
  logic [14:0] thermoL, thermoR;
  logic [13:0] binL, binR;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [17:0] expL = '0, expR = '0;

  always #(ClkPeriod/2) clk = ~clk;

  dual_dac_input u0 (
    .clk(clk), .rst(rst), .dataL(dataL), .dataR(dataR),
    .latL(latL), .latR(latR),
    .holdL(holdL), .thermoL(thermoL), .binL(binL),
    .holdR(holdR), .thermoR(thermoR), .binR(binR)
  );

  function automatic logic [14:0] thermOf(input logic [17:0] w);
    logic [3:0]  n;
    logic [15:0] t;
    n = {~w[17], w[16:14]};
    t = (16'd1 << n) - 16'd1;
    return t[14:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkBoth(input string req);
    chk(req, 32'(holdL), 32'(expL));
    chk({req, " R8 left"}, 32'(thermoL), 32'(thermOf(expL)));
    chk({req, " R9 left"}, 32'(binL), 32'(expL[13:0]));
    chk(req, 32'(holdR), 32'(expR));
    chk({req, " R8 right"}, 32'(thermoR), 32'(thermOf(expR)));
    chk({req, " R9 right"}, 32'(binR), 32'(expR[13:0]));
  endtask

  // last bit goes out together with the falling strobe(s)
  task automatic sendFrame(input logic [17:0] wl, input logic [17:0] wr,
                           input logic [1:0] mask, input int nBits);
    for (int b = nBits - 1; b >= 0; b--) begin
      @(negedge clk);
      dataL = (b < 18) ? wl[b] : ~wl[0];
      dataR = (b < 18) ? wr[b] : ~wr[0];
      if (b == 0) begin
        latL = ~mask[0];
        latR = ~mask[1];
      end
    end
    @(negedge clk);
    latL = 1'b1;
    latR = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chkBoth("R1 reset");

    // vector table: R2 R5 R6 R8 R9
    for (int v = 0; v < NumVec; v++) begin
      logic [1:0] m;
      m = VecTab[v][37:36];
      sendFrame(VecTab[v][35:18], VecTab[v][17:0], m, 18);
      if (m[0]) expL = VecTab[v][35:18];
      if (m[1]) expR = VecTab[v][17:0];
      chkBoth("R2 R5 R6 table");
    end

    // R2: 22-bit frame, oldest 4 bits pushed out
    sendFrame(18'h2A5A5, 18'h15A5A, 2'b11, 22);
    expL = 18'h2A5A5; expR = 18'h15A5A;
    chkBoth("R2 overlong");

    // R3: exact update timing
    for (int b = 17; b >= 0; b--) begin
      @(negedge clk);
      dataL = 1'(18'h0BEEF >> b);
      dataR = 1'(18'h31337 >> b);
      if (b == 0) begin latL = 1'b0; latR = 1'b0; end
    end
    @(negedge clk);
    chk("R3 before update", 32'(holdL), 32'(expL));
    chk("R3 before update", 32'(holdR), 32'(expR));
    latL = 1'b1; latR = 1'b1;
    @(negedge clk);
    expL = 18'h0BEEF; expR = 18'h31337;
    chk("R3 after update", 32'(holdL), 32'(expL));
    chk("R3 after update", 32'(holdR), 32'(expR));

    // R4: strobes held low through a new frame, then high through another
    @(negedge clk);
    latL = 1'b0; latR = 1'b0;
    for (int b = 17; b >= 0; b--) begin
      @(negedge clk);
      dataL = 1'(18'h15555 >> b);
      dataR = 1'(18'h2AAAA >> b);
    end
    repeat (3) @(negedge clk);
    expL = 18'h00000; expR = 18'h00000;
    // the fall at the start loaded whatever was shifted then; capture it
    expL = holdL; expR = holdR;
    for (int b = 17; b >= 0; b--) begin
      @(negedge clk);
      dataL = 1'(18'h3C3C3 >> b);
      dataR = 1'(18'h0F00F >> b);
    end
    repeat (3) @(negedge clk);
    chk("R4 level low no reload", 32'(holdL), 32'(expL));
    chk("R4 level low no reload", 32'(holdR), 32'(expR));
    latL = 1'b1; latR = 1'b1;
    for (int b = 17; b >= 0; b--) begin
      @(negedge clk);
      dataL = 1'(18'h01234 >> b);
      dataR = 1'(18'h3FEDC >> b);
    end
    repeat (3) @(negedge clk);
    chk("R4 level high no reload", 32'(holdL), 32'(expL));
    chk("R4 level high no reload", 32'(holdR), 32'(expR));

    // R7: one data stream and one common strobe feed both channels
    for (int b = 17; b >= 0; b--) begin
      @(negedge clk);
      dataL = 1'(18'h2F00D >> b);
      dataR = dataL;
      if (b == 0) begin latL = 1'b0; latR = latL; end
    end
    @(negedge clk);
    latL = 1'b1; latR = latL;
    @(negedge clk);
    expL = 18'h2F00D; expR = 18'h2F00D;
    chkBoth("R7 R6 tied inputs");

    // R1: reset after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expL = '0; expR = '0;
    chkBoth("R1 reset again");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule